// File: doc/BRIEF.md
# Asynchronous Byte-SRAM Bus Controller

This block sits between a simple synchronous host port and an asynchronous 8K x 8 static memory. The host raises `req` with a direction bit, a 13-bit byte address and, for stores, a data byte. The controller turns this into active-low chip-enable, write-enable and output-enable strobes, a held address and a data bus. It pulses `ready` once the access has finished. For loads, it returns the captured byte on `rdata`.

Every memory timing limit is a nanosecond parameter. Each one is converted to whole clocks by rounding up against the clock-period parameter. In a store, chip-enable and write-enable fall on the same edge and rise on the same edge. The write window therefore lasts for the longest of the write-enable pulse, the chip-enable pulse, the data setup and the address setup limits. Output-enable stays high for the whole store. The data byte is driven for one extra clock beyond the rounded hold time after the strobes rise. The bidirectional data pins are split into `mem_dq_out`, `mem_dq_oe` and `mem_dq_in`, so that a pad cell at chip level can join them.

Top module: `asram_ctrl`

## Requirements
- R1: While `rst_n` is low, and on leaving reset, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `ready` is 0 and `rdata` is 0.
- R2: A request with `we`=0 that is accepted at clock edge A drives `mem_ce_n`=0, `mem_oe_n`=0, `mem_we_n`=1 and `mem_addr`=`addr`. This holds from edge A for N_ACC = ceil(ACCESS_NS/CLK_NS) cycles, which is 7 with the defaults.
- R3: A load samples `mem_dq_in` on the edge that ends its strobe window (A+N_ACC). In the cycle that follows, `ready` is 1 for exactly one cycle and `rdata` holds the sampled byte. `rdata` keeps that value until the next load completes.
- R4: A store accepted at edge A pulls `mem_ce_n` and `mem_we_n` low together from edge A. Both rise together after N_LOW cycles. N_LOW is the largest of the rounded write-enable pulse (50 ns), chip-enable pulse (55 ns), data setup (30 ns) and address setup (60 ns) limits, which is 6 with the defaults.
- R5: During a store, `mem_oe_n` stays 1. `mem_dq_oe` is 1 with `mem_dq_out`=`wdata` from edge A until N_HOLD = ceil(5 ns/CLK_NS)+1 cycles (2 with the defaults) after the strobes rise. It then returns to 0.
- R6: `mem_addr` stays constant for the whole of an access: through every cycle with `mem_ce_n` low and through the data hold of a store.
- R7: A store completes with `ready`=1 in the cycle after max(ceil(70 ns/CLK_NS), N_LOW+N_HOLD) cycles have passed since edge A. This is cycle 9 counting the first cycle after edge A as 1, so `ready` is seen at A+8 with the defaults.
- R8: A `req` that arrives while an access is in progress is ignored. It changes no memory pin and starts no access after the current one completes.
- R9: A request that is presented in the cycle where `ready` is 1 is accepted at the next edge. Its strobes start one cycle after the completion pulse.
- R10: The controller never drives the data bus (`mem_dq_oe`=1) while `mem_oe_n` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Host access request; taken only when idle |
| we | input | 1 | 1 = store, 0 = load |
| addr | input | 13 | Host byte address |
| wdata | input | 8 | Host store data |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last byte loaded from memory |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 13 | Memory address |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 8 | Data from the memory |

## Verification
The completion of one access and the acceptance of the next can fall in the same cycle. The cycle where `ready` is high is already idle, so a request held in that cycle is taken at the following edge. The bench provokes this by issuing each new request as soon as its reference model reports idle, which is always the completion cycle. It then checks that the chip enable falls one cycle later, and that the previous `rdata` and address do not disturb the new access. It also sends requests during busy windows and confirms that the pins and the following idle cycles show nothing new.

// File: rtl/asram_pkg.sv
// Shared types and compile-time helpers for the asynchronous SRAM controller.
// Assumes all timing parameters are positive nanosecond values.
package asram_pkg;

    // Sequencer phases; order carries no meaning.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_READ,
        PH_WLOW,
        PH_WHOLD,
        PH_WREC
    } phase_e;

    // Ceiling division of a nanosecond limit by the clock period.
    function automatic int unsigned ns2clk(int unsigned ns, int unsigned period);
        return (ns + period - 1) / period;
    endfunction

    // Larger of two counts.
    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_step_timer.sv
// Loadable down-counter that measures the length of one sequencer phase.
// Assumes load values are at least 1; 'last' flags the final cycle of a phase.
module asram_step_timer #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);

    logic [CW-1:0] cnt_q;

    // Count down the cycles left in the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // The phase ends when one cycle remains.
    always_comb last = (cnt_q == CW'(1));

endmodule

// File: rtl/asram_seq.sv
// Phase sequencer: accepts a host request when idle and walks the load or
// store phases, reloading the step timer at every phase entry.
// Assumes N_ACC, N_LOW and N_HOLD are at least 1; N_REC may be 0.
module asram_seq import asram_pkg::*; #(
    parameter int unsigned CW     = 4,
    parameter int unsigned N_ACC  = 7,
    parameter int unsigned N_LOW  = 6,
    parameter int unsigned N_HOLD = 2,
    parameter int unsigned N_REC  = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic          last,
    output phase_e        phase_q,
    output phase_e        phase_d,
    output logic          load,
    output logic [CW-1:0] load_val,
    output logic          accept,
    output logic          finish
);

    localparam logic [CW-1:0] L_ACC  = CW'(N_ACC);
    localparam logic [CW-1:0] L_LOW  = CW'(N_LOW);
    localparam logic [CW-1:0] L_HOLD = CW'(N_HOLD);
    localparam logic [CW-1:0] L_REC  = CW'(N_REC);
    localparam bit            HAS_REC = (N_REC != 0);

    // Next-phase and timer-load decision.
    always_comb begin
        phase_d  = phase_q;
        load     = 1'b0;
        load_val = '0;
        accept   = 1'b0;
        finish   = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (req) begin
                    accept = 1'b1;
                    load   = 1'b1;
                    if (we) begin
                        phase_d  = PH_WLOW;
                        load_val = L_LOW;
                    end else begin
                        phase_d  = PH_READ;
                        load_val = L_ACC;
                    end
                end
            end
            PH_READ: begin
                if (last) begin
                    phase_d = PH_IDLE;
                    finish  = 1'b1;
                end
            end
            PH_WLOW: begin
                if (last) begin
                    phase_d  = PH_WHOLD;
                    load     = 1'b1;
                    load_val = L_HOLD;
                end
            end
            PH_WHOLD: begin
                if (last) begin
                    if (HAS_REC) begin
                        phase_d  = PH_WREC;
                        load     = 1'b1;
                        load_val = L_REC;
                    end else begin
                        phase_d = PH_IDLE;
                        finish  = 1'b1;
                    end
                end
            end
            PH_WREC: begin
                if (last) begin
                    phase_d = PH_IDLE;
                    finish  = 1'b1;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

endmodule

// File: rtl/asram_pins.sv
// Pin stage: registers every memory strobe from the next phase so that the
// pins change only on clock edges, holds address and store data from
// acceptance, and captures load data at the end of the access window.
// Assumes accept and finish come from the phase sequencer.
module asram_pins import asram_pkg::*; #(
    parameter int unsigned AW = 13,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        phase_q,
    input  phase_e        phase_d,
    input  logic          accept,
    input  logic          finish,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic [DW-1:0] mem_dq_in,
    output logic          mem_ce_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic          mem_dq_oe,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    output logic          ready,
    output logic [DW-1:0] rdata
);

    // Strobes and drive enable, decoded from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ce_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_ce_n  <= !(phase_d == PH_READ || phase_d == PH_WLOW);
            mem_we_n  <= !(phase_d == PH_WLOW);
            mem_oe_n  <= !(phase_d == PH_READ);
            mem_dq_oe <= (phase_d == PH_WLOW) || (phase_d == PH_WHOLD);
        end
    end

    // Address and store data latched once per accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= host_addr;
            mem_dq_out <= host_wdata;
        end
    end

    // Completion pulse and load-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready <= 1'b0;
            rdata <= '0;
        end else begin
            ready <= finish;
            if (finish && phase_q == PH_READ) rdata <= mem_dq_in;
        end
    end

endmodule

// File: rtl/asram_ctrl.sv
// Asynchronous 8K x 8 SRAM controller top. Converts nanosecond limits into
// clock counts, sequences load and store phases and drives the memory pins.
// Assumes a single clock and a pad cell outside this block joining the
// split data pins into one bidirectional bus.
module asram_ctrl import asram_pkg::*; #(
    parameter int unsigned AW            = 13,
    parameter int unsigned DW            = 8,
    parameter int unsigned CLK_NS        = 10,
    parameter int unsigned ACCESS_NS     = 70,
    parameter int unsigned WE_PULSE_NS   = 50,
    parameter int unsigned CE_PULSE_NS   = 55,
    parameter int unsigned DATA_SETUP_NS = 30,
    parameter int unsigned ADDR_SETUP_NS = 60,
    parameter int unsigned DATA_HOLD_NS  = 5,
    parameter int unsigned CYCLE_NS      = 70
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          ready,
    output logic [DW-1:0] rdata,
    output logic          mem_ce_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);

    localparam int unsigned N_ACC  = max2(1, ns2clk(ACCESS_NS, CLK_NS));
    localparam int unsigned N_LOW  = max2(1, max2(
                                         max2(ns2clk(WE_PULSE_NS, CLK_NS), ns2clk(CE_PULSE_NS, CLK_NS)),
                                         max2(ns2clk(DATA_SETUP_NS, CLK_NS), ns2clk(ADDR_SETUP_NS, CLK_NS))));
    localparam int unsigned N_HOLD = ns2clk(DATA_HOLD_NS, CLK_NS) + 1;
    localparam int unsigned N_WC   = ns2clk(CYCLE_NS, CLK_NS);
    localparam int unsigned N_REC  = (N_WC > N_LOW + N_HOLD) ? (N_WC - N_LOW - N_HOLD) : 0;
    localparam int unsigned N_MAX  = max2(max2(N_ACC, N_LOW), max2(N_HOLD, N_REC));
    localparam int unsigned CW     = $clog2(N_MAX + 1);

    phase_e        phase_q;
    phase_e        phase_d;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_last;
    logic          accept;
    logic          finish;

    asram_step_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    asram_seq #(
        .CW     (CW),
        .N_ACC  (N_ACC),
        .N_LOW  (N_LOW),
        .N_HOLD (N_HOLD),
        .N_REC  (N_REC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .we       (we),
        .last     (tmr_last),
        .phase_q  (phase_q),
        .phase_d  (phase_d),
        .load     (tmr_load),
        .load_val (tmr_val),
        .accept   (accept),
        .finish   (finish)
    );

    asram_pins #(.AW(AW), .DW(DW)) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_q    (phase_q),
        .phase_d    (phase_d),
        .accept     (accept),
        .finish     (finish),
        .host_addr  (addr),
        .host_wdata (wdata),
        .mem_dq_in  (mem_dq_in),
        .mem_ce_n   (mem_ce_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_dq_oe  (mem_dq_oe),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .ready      (ready),
        .rdata      (rdata)
    );

endmodule

// File: rtl/asram_ctrl_chk.sv
// Protocol checker for the SRAM controller pins, bound to the top module.
// Assumes a synchronous active-low reset; counts the write-enable low time.
module asram_ctrl_chk #(
    parameter int unsigned AW    = 13,
    parameter int unsigned N_LOW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_ce_n,
    input logic          mem_we_n,
    input logic          mem_oe_n,
    input logic          mem_dq_oe,
    input logic [AW-1:0] mem_addr,
    input logic          ready
);

    logic [15:0] lo_cnt;

    // Length of the current write-enable low stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)        lo_cnt <= '0;
        else if (mem_we_n) lo_cnt <= '0;
        else               lo_cnt <= lo_cnt + 16'd1;
    end

    p_joint_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $fell(mem_ce_n));

    p_joint_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> $rose(mem_ce_n));

    p_pulse_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (lo_cnt == 16'(N_LOW)));

    p_oe_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    p_hold_after_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe);

    p_addr_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    p_ready_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    p_no_contention_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

endmodule

bind asram_ctrl asram_ctrl_chk #(.AW(AW), .N_LOW(N_LOW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe),
    .mem_addr  (mem_addr),
    .ready     (ready)
);

// File: tb/test_asram_ctrl.sv
// Bench for asram_ctrl: behavioural reference model compared on every clock.
module test_asram_ctrl;

    localparam int E_ACC  = 7;  // ceil(70/10)
    localparam int E_LOW  = 6;  // max of ceil(50,55,30,60 / 10)
    localparam int E_HOLD = 2;  // ceil(5/10)+1
    localparam int E_WTOT = 8;  // max(ceil(70/10), E_LOW+E_HOLD)

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req;
    logic        we;
    logic [12:0] addr;
    logic [7:0]  wdata;
    logic        ready;
    logic [7:0]  rdata;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [12:0] mem_addr;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in;

    int checks = 0;
    int fails  = 0;
    bit started = 1'b0;

    logic [7:0] chip [0:8191];
    logic [7:0] refm [0:8191];

    // reference model state
    bit          m_busy;
    bit          m_we;
    int          m_t;
    logic [12:0] m_addr;
    logic [7:0]  m_wd;
    bit          m_ready;
    bit          m_last_we;
    logic [7:0]  m_rdata;

    always #5 clk = ~clk;

    asram_ctrl i_asram_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .ready(ready), .rdata(rdata), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // memory device model: drives only in a read window
    assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? chip[mem_addr] : 8'hEE;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference model advanced on each clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_t = 0; m_ready = 0; m_rdata = 8'h00; m_we = 0; m_last_we = 0;
        end else begin
            m_ready = 0;
            if (m_busy) begin
                m_t++;
                if (( m_we && m_t == E_WTOT + 1) || (!m_we && m_t == E_ACC + 1)) begin
                    m_busy = 0;
                    m_ready = 1;
                    m_last_we = m_we;
                    if (!m_we) m_rdata = refm[m_addr];
                end
            end else if (req) begin
                m_busy = 1; m_t = 1; m_we = we; m_addr = addr; m_wd = wdata;
                if (we) refm[addr] = wdata;
            end
        end
    end

    // Device write commit: at the end of a window with both strobes low.
    bit prev_wlow = 0;
    always @(negedge clk) begin
        if (prev_wlow && (mem_we_n || mem_ce_n))
            chip[mem_addr] = mem_dq_oe ? mem_dq_out : 8'hEE;
        prev_wlow = !mem_we_n && !mem_ce_n;
    end

    // Compare the design against the model away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            bit e_ce, e_we, e_oe, e_drv;
            string tg;
            if (m_busy && m_we) begin
                e_ce = (m_t <= E_LOW) ? 1'b0 : 1'b1;
                e_we = e_ce;
                e_oe = 1'b1;
                e_drv = (m_t <= E_LOW + E_HOLD);
                tg = "R4";
            end else if (m_busy) begin
                e_ce = 0; e_we = 1; e_oe = 0; e_drv = 0; tg = "R2";
            end else begin
                e_ce = 1; e_we = 1; e_oe = 1; e_drv = 0; tg = "R8";
            end
            check(mem_ce_n == e_ce, tg, "ce_n", mem_ce_n, e_ce);
            check(mem_we_n == e_we, tg, "we_n", mem_we_n, e_we);
            check(mem_oe_n == e_oe, (m_busy && m_we) ? "R5" : tg, "oe_n", mem_oe_n, e_oe);
            check(mem_dq_oe == e_drv, (m_busy && m_we) ? "R5" : tg, "dq_oe", mem_dq_oe, e_drv);
            check(!(mem_dq_oe && !mem_oe_n), "R10", "bus contention", mem_dq_oe, 0);
            if (m_busy) check(mem_addr == m_addr, "R6", "mem_addr", mem_addr, m_addr);
            if (e_drv) check(mem_dq_out == m_wd, "R5", "dq_out", mem_dq_out, m_wd);
            check(ready == m_ready, m_last_we ? "R7" : "R3", "ready", ready, m_ready);
            if (m_ready && !m_last_we)
                check(rdata == m_rdata, "R3", "rdata", rdata, m_rdata);
        end
    end

    task automatic wait_idle();
        while (m_busy) @(negedge clk);
    endtask

    task automatic issue(input bit w, input logic [12:0] a, input logic [7:0] d);
        bit in_ready;
        wait_idle();
        in_ready = m_ready;
        req = 1'b1; we = w; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0;
        if (in_ready) check(mem_ce_n == 1'b0, "R9", "ce_n after ready-cycle request", mem_ce_n, 0);
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog: actual hung expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Stimulus.
    initial begin
        for (int i = 0; i < 8192; i++) begin chip[i] = 8'h00; refm[i] = 8'h00; end
        rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        check(mem_ce_n && mem_we_n && mem_oe_n, "R1", "strobes in reset",
              {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
        check(mem_dq_oe == 1'b0, "R1", "dq_oe in reset", mem_dq_oe, 0);
        check(ready == 1'b0, "R1", "ready in reset", ready, 0);
        check(rdata == 8'h00, "R1", "rdata in reset", rdata, 0);
        rst_n = 1'b1;
        started = 1'b1;
        @(negedge clk);

        issue(1'b1, 13'h0000, 8'hA5);
        issue(1'b0, 13'h0000, 8'h00);
        issue(1'b1, 13'h1FFF, 8'h3C);
        issue(1'b0, 13'h1FFF, 8'h00);
        issue(1'b0, 13'h0800, 8'hFF);   // never written: reads 00

        // R8: requests during a busy store are ignored
        issue(1'b1, 13'h0123, 8'h77);
        repeat (2) @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 13'h1111; wdata = 8'h99;
        repeat (2) @(negedge clk);
        req = 1'b0;
        wait_idle();
        repeat (4) @(negedge clk);
        issue(1'b0, 13'h1111, 8'h00);
        issue(1'b0, 13'h0123, 8'h00);

        // R8: request during a busy load is ignored
        issue(1'b0, 13'h0000, 8'h00);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 13'h0000; wdata = 8'h11;
        @(negedge clk);
        req = 1'b0;
        wait_idle();
        repeat (3) @(negedge clk);
        issue(1'b0, 13'h0000, 8'h00);

        // Back-to-back patterns (R9 on each)
        for (int i = 0; i < 16; i++)
            issue(1'b1, 13'((i * 619) & 13'h1FFF), 8'((i * 29) ^ 8'h5A));
        for (int i = 15; i >= 0; i--)
            issue(1'b0, 13'((i * 619) & 13'h1FFF), 8'h00);
        for (int i = 0; i < 6; i++) begin
            issue(1'b1, 13'(i * 1365), 8'(8'hF0 - i));
            issue(1'b0, 13'(i * 1365), 8'h00);
        end

        wait_idle();
        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule